// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This block is the register front end of a single channel of a descriptor-driven DMA engine. A processor reaches it over a simple synchronous 32-bit register port. The port carries an enable, a write flag, an address, a byte size, write data and combinational read data. The unit keeps a 16-bit channel status word and a 32-bit command pointer. It turns software writes to a control register into status updates, and it raises one-cycle request pulses toward the channel engine: start, abort, pause and resume.

A control write carries a 16-bit bit-select in its upper half. Only the status bits picked by that select take the value from the lower half. The other bits keep their old value. Changes of the run, wake and pause bits then adjust the active flag and decide which request pulse fires. The command pointer can only be loaded while the channel is idle. Bus data is little-endian, so the bytes of each 32-bit word are reversed against the internal layout.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset the status word and the command pointer are zero, and all four request pulses are low.
- R2: Only accesses with a size of 4 bytes take effect. A read of any other size returns zero, and a write of any other size changes nothing.
- R3: Bus words are byte-reversed against the internal layout. A status read at offset 0x4 returns {S[7:0], S[15:8], 16'h0}. A control write at offset 0x0 is decoded from the byte-reversed write word V, with select mask M = V[31:16] and data D = V[15:0].
- R4: A read of the control offset 0x0 always returns zero. Any offset other than 0x0, 0x4 and 0xC reads zero and ignores writes.
- R5: A control write stores (D & M & 16'hF0FF) | (S & ~M). Bits 8 to 11 are never set from software. The status bits are: ACTIVE bit 10, DEAD bit 11, WAKE bit 12, FLUSH bit 13, PAUSE bit 14, RUN bit 15.
- R6: When RUN goes from 0 to 1, ACTIVE is set. A start pulse fires unless the resulting PAUSE bit is set.
- R7: When RUN goes from 1 to 0, ACTIVE and DEAD are cleared and an abort pulse fires.
- R8: When RUN is unchanged but WAKE changes in either direction, ACTIVE is set. A resume pulse fires unless the resulting PAUSE bit is set.
- R9: When neither RUN nor WAKE changes and PAUSE goes from 0 to 1, ACTIVE is cleared and a pause pulse fires. A fall of PAUSE changes nothing else and fires no pulse.
- R10: FLUSH is never left set after a control write.
- R11: Writes to the status offset 0x4 change nothing.
- R12: A write at offset 0xC loads the command pointer with the bus word unchanged, but only while both RUN and ACTIVE are clear.
- R13: Each request pulse lasts one cycle and appears in the cycle after the accepted control write. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, bus byte order |
| acc_rdata | output | 32 | Read data, bus byte order, combinational |
| cmd_ptr | output | 32 | Command pointer toward the engine |
| start_pulse | output | 1 | Start request |
| abort_pulse | output | 1 | Abort request |
| pause_pulse | output | 1 | Pause request |
| resume_pulse | output | 1 | Resume request |

## Verification
The bench builds the unit with the default 8-bit offset width. That width makes the unlisted offsets 0x8 and 0x10 reachable, so the bench can show they are ignored next to the three real registers. Directed sequences walk the status word through run rise and fall, both wake directions, pause rise and fall, a flush request, and a start requested together with pause. A behavioural model then shadows every access and is compared on every clock.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic [31:0]       cmd_ptr,
  output logic              start_pulse,
  output logic              abort_pulse,
  output logic              pause_pulse,
  output logic              resume_pulse
);
  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_PTR  = ADDR_W'(4'hC);
  localparam int B_ACT = 10, B_DEAD = 11, B_WAKE = 12, B_FLSH = 13, B_PAUS = 14, B_RUN = 15;
  localparam logic [15:0] SW_MASK = 16'hF0FF;

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  logic [15:0] stat_q, nxt;
  logic        do_start, do_abort, do_pause, do_resume;

  wire         full_acc = acc_en && (acc_size == 3'd4);
  wire         wr_ok    = full_acc && acc_wr;
  wire         ctl_wr   = wr_ok && (acc_addr == OFF_CTL);
  wire         ptr_wr   = wr_ok && (acc_addr == OFF_PTR) && !stat_q[B_RUN] && !stat_q[B_ACT];
  wire [31:0]  wv       = bswap(acc_wdata);
  wire [15:0]  sel      = wv[31:16];

  always_comb begin
    nxt       = (wv[15:0] & sel & SW_MASK) | (stat_q & ~sel);
    do_start  = 1'b0;
    do_abort  = 1'b0;
    do_pause  = 1'b0;
    do_resume = 1'b0;
    if (nxt[B_RUN] != stat_q[B_RUN]) begin
      if (nxt[B_RUN]) begin
        nxt[B_ACT] = 1'b1;
        do_start   = !nxt[B_PAUS];
      end else begin
        nxt[B_ACT]  = 1'b0;
        nxt[B_DEAD] = 1'b0;
        do_abort    = 1'b1;
      end
    end else if (nxt[B_WAKE] != stat_q[B_WAKE]) begin
      nxt[B_ACT] = 1'b1;
      do_resume  = !nxt[B_PAUS];
    end else if (nxt[B_PAUS] && !stat_q[B_PAUS]) begin
      nxt[B_ACT] = 1'b0;
      do_pause   = 1'b1;
    end
    nxt[B_FLSH] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q       <= '0;
      cmd_ptr      <= '0;
      start_pulse  <= 1'b0;
      abort_pulse  <= 1'b0;
      pause_pulse  <= 1'b0;
      resume_pulse <= 1'b0;
    end else begin
      if (ctl_wr) stat_q <= nxt;
      if (ptr_wr) cmd_ptr <= acc_wdata;
      start_pulse  <= ctl_wr && do_start;
      abort_pulse  <= ctl_wr && do_abort;
      pause_pulse  <= ctl_wr && do_pause;
      resume_pulse <= ctl_wr && do_resume;
    end
  end

  assign acc_rdata = (full_acc && !acc_wr && acc_addr == OFF_STAT) ? bswap({16'h0, stat_q}) : 32'h0;
endmodule

module dma_ctl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [2:0]        acc_size,
  input logic [31:0]       acc_rdata,
  input logic [15:0]       stat,
  input logic [31:0]       cmd_ptr,
  input logic              start_pulse,
  input logic              abort_pulse,
  input logic              pause_pulse,
  input logic              resume_pulse
);
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, abort_pulse, pause_pulse, resume_pulse})); // R13
  AST_START_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (stat[15] && stat[10] && !stat[14])); // R6
  AST_ABORT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!stat[15] && !stat[10] && !stat[11])); // R7
  AST_PAUSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_pulse |-> (stat[14] && !stat[10])); // R9
  AST_FLUSH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[13]); // R10
  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[15] || stat[10]) |=> $stable(cmd_ptr)); // R12
  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_size != 3'd4) |=> ($stable(stat) && $stable(cmd_ptr))); // R2
  AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr == '0) |-> acc_rdata == 32'h0); // R4
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .acc_size(acc_size), .acc_rdata(acc_rdata), .stat(stat_q), .cmd_ptr(cmd_ptr),
  .start_pulse(start_pulse), .abort_pulse(abort_pulse), .pause_pulse(pause_pulse),
  .resume_pulse(resume_pulse));

// File: tb/dma_ctl_regs_test.sv
`timescale 1ns/1ps
module dma_ctl_regs_test;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [7:0] acc_addr = 0;
  logic [2:0] acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata, cmd_ptr;
  logic start_pulse, abort_pulse, pause_pulse, resume_pulse;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_ctl_regs #(.ADDR_W(8)) uut (.*);

  // behavioural reference model
  int m_stat = 0;
  logic [31:0] m_ptr = 0;
  logic [3:0] m_pul = 0;   // {start, abort, pause, resume}

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic int bit_of(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk) begin
    int v, msk, n, old;
    logic [3:0] p;
    p = 0;
    if (!rst_n) begin
      m_stat = 0; m_ptr = 0;
    end else if (acc_en && acc_wr && acc_size == 4) begin
      if (acc_addr == 8'h00) begin
        v = int'(rev(acc_wdata));
        msk = (v >> 16) & 'hFFFF;
        old = m_stat;
        n = ((v & 'hFFFF) & msk & 'hF0FF) | (old & ~msk & 'hFFFF);
        if (bit_of(n, 15) != bit_of(old, 15)) begin
          if (bit_of(n, 15) == 1) begin n = n | 'h400; if (bit_of(n, 14) == 0) p = 4'b1000; end
          else begin n = n & ~'hC00; p = 4'b0100; end
        end else if (bit_of(n, 12) != bit_of(old, 12)) begin
          n = n | 'h400; if (bit_of(n, 14) == 0) p = 4'b0001;
        end else if (bit_of(n, 14) == 1 && bit_of(old, 14) == 0) begin
          n = n & ~'h400; p = 4'b0010;
        end
        m_stat = n & ~'h2000 & 'hFFFF;
      end else if (acc_addr == 8'h0C && bit_of(m_stat, 15) == 0 && bit_of(m_stat, 10) == 0)
        m_ptr = acc_wdata;
    end
    m_pul <= p;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] er;
    check("R13 pulses", {28'h0, start_pulse, abort_pulse, pause_pulse, resume_pulse}, {28'h0, m_pul});
    check("R12 cmd_ptr", cmd_ptr, m_ptr);
    er = (acc_en && !acc_wr && acc_size == 4 && acc_addr == 8'h04) ? rev(32'(m_stat)) : 32'h0;
    check("R3 rdata", acc_rdata, er);
  end

  function automatic logic [31:0] ctl(input logic [15:0] m, input logic [15:0] d);
    return rev({m, d});
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz,
                    input logic [3:0] ep, input string req);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    check(req, {28'h0, start_pulse, abort_pulse, pause_pulse, resume_pulse}, {28'h0, ep});
    @(negedge clk);
    check("R13 one cycle", {28'h0, start_pulse, abort_pulse, pause_pulse, resume_pulse}, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_size = sz;
    #1 check(req, acc_rdata, exp);
    @(negedge clk);
    acc_en = 0;
  endtask

  function automatic logic [31:0] st(input logic [15:0] s);
    return {s[7:0], s[15:8], 16'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h04, 3'd4, 32'h0, "R1 status after reset");
    check("R1 cmd_ptr after reset", cmd_ptr, 32'h0);
    wr(8'h0C, 32'h1234_5678, 3'd4, 4'b0000, "R12 load pointer");
    check("R12 pointer loaded", cmd_ptr, 32'h1234_5678);
    wr(8'h00, ctl(16'h8000, 16'h8000), 3'd2, 4'b0000, "R2 narrow write");
    rd(8'h04, 3'd4, 32'h0, "R2 narrow write ignored");
    wr(8'h00, ctl(16'h8000, 16'h8000), 3'd4, 4'b1000, "R6 start pulse");
    rd(8'h04, 3'd4, st(16'h8400), "R6 R3 status after run");
    rd(8'h04, 3'd1, 32'h0, "R2 narrow read");
    rd(8'h00, 3'd4, 32'h0, "R4 control reads zero");
    rd(8'h08, 3'd4, 32'h0, "R4 unlisted read");
    wr(8'h0C, 32'hDEAD_BEEF, 3'd4, 4'b0000, "R12 locked write");
    check("R12 pointer held", cmd_ptr, 32'h1234_5678);
    wr(8'h00, ctl(16'h0300, 16'h0300), 3'd4, 4'b0000, "R5 reserved bits");
    rd(8'h04, 3'd4, st(16'h8400), "R5 bits 8-9 not set");
    wr(8'h00, ctl(16'h00FF, 16'h00A5), 3'd4, 4'b0000, "R5 masked low bits");
    rd(8'h04, 3'd4, st(16'h84A5), "R5 status");
    wr(8'h00, ctl(16'h1000, 16'h1000), 3'd4, 4'b0001, "R8 resume on wake rise");
    rd(8'h04, 3'd4, st(16'h94A5), "R8 status");
    wr(8'h00, ctl(16'h4000, 16'h4000), 3'd4, 4'b0010, "R9 pause pulse");
    rd(8'h04, 3'd4, st(16'hD0A5), "R9 active cleared");
    wr(8'h00, ctl(16'h1000, 16'h0000), 3'd4, 4'b0000, "R8 resume held by pause");
    rd(8'h04, 3'd4, st(16'hC4A5), "R8 active set on wake fall");
    wr(8'h00, ctl(16'h4000, 16'h0000), 3'd4, 4'b0000, "R9 pause fall no pulse");
    rd(8'h04, 3'd4, st(16'h84A5), "R9 status");
    wr(8'h00, ctl(16'h2000, 16'h2000), 3'd4, 4'b0000, "R10 flush");
    rd(8'h04, 3'd4, st(16'h84A5), "R10 flush cleared");
    wr(8'h04, 32'hFFFF_FFFF, 3'd4, 4'b0000, "R11 status write");
    rd(8'h04, 3'd4, st(16'h84A5), "R11 status unchanged");
    wr(8'h10, ctl(16'hFFFF, 16'h0000), 3'd4, 4'b0000, "R4 unlisted write");
    rd(8'h04, 3'd4, st(16'h84A5), "R4 status unchanged");
    wr(8'h00, ctl(16'h8000, 16'h0000), 3'd4, 4'b0100, "R7 abort pulse");
    rd(8'h04, 3'd4, st(16'h00A5), "R7 active cleared");
    wr(8'h0C, 32'hCAFE_F00D, 3'd4, 4'b0000, "R12 idle write");
    check("R12 pointer reloaded", cmd_ptr, 32'hCAFE_F00D);
    wr(8'h00, ctl(16'hC000, 16'hC000), 3'd4, 4'b0000, "R6 start held by pause");
    rd(8'h04, 3'd4, st(16'hC4A5), "R6 status with pause");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule